// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Modulator with Dead Time

This block turns a set of per-phase duty words into gate commands for a multi-phase buck regulator. Every phase has a high-side command and a separate low-side command. A programmable dead time keeps the two commands of one phase from being active together. All active phases share one switching period, measured in system clock cycles. Their period starts are spread evenly across that period, so the ripple of the phases partly cancels.

The control loop supplies the duty word of each phase, the period word, the dead-time word and the number of active phases. An enable pin switches the whole stage off. Two fast flags from the output-voltage monitor bypass normal modulation. On a droop, every active phase turns its high side on. On an overshoot, every phase is turned fully off. Both flags act combinationally on the outputs, with no wait for a period boundary.

Words are taken into a phase only at the start of its own period, so a pulse already running is never cut or stretched by a mid-period update. A duty word too large to leave room for both dead-time gaps is clamped.

Top module: `mphase_pwm`

## Requirements
- R1: A phase never has its high-side output and its low-side output high in the same cycle.
- R2: With a steady configuration, the dead-time word T sets two gaps. After a phase's high-side output falls, its low-side output stays low for exactly T cycles. After the low-side output falls, the high-side output stays low for exactly T cycles. After any change of a dead-time word, each gap is still at least the previously latched T.
- R3: With a steady configuration, each phase repeats every P cycles, where P is the effective period word. Phase k starts its period floor(k*P/N) cycles after phase 0, where N is the effective phase count.
- R4: In each period of a phase, the high-side output is high for D cycles and the low-side output is high for P-D-2T cycles, where D is the effective duty. A period word below 4 is treated as 4.
- R5: A duty word larger than P-2T is clamped to P-2T. When P is at most 2T, the duty is clamped to 0.
- R6: While the enable input is low, all high-side and low-side outputs are low in the same cycle. Normal switching resumes once enable returns high.
- R7: While the droop flag is high, every active phase has its low-side output low at once. Its high-side output goes high within T cycles and stays high. Droop takes precedence over overshoot.
- R8: While the overshoot flag is high and droop is low, all outputs are low in the same cycle.
- R9: Each phase samples its duty word and the dead-time word only at the start of its own period. A change in the middle of a period does not alter the pulse in progress. The period word and the phase count are sampled at the start of phase 0's period.
- R10: A phase-count value of 0 is treated as 1, and a value above 6 is treated as 6. Phases with index N or higher hold both outputs low.
- R11: During reset, and after reset until a phase's first period begins, both outputs of that phase are low, even while droop is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Stage enable; low forces all outputs low |
| droop_i | input | 1 | Droop flag: active phases drive the high side |
| over_i | input | 1 | Overshoot flag: all outputs off |
| nph_i | input | 3 | Requested number of active phases |
| period_i | input | 10 | Switching period in clock cycles |
| dead_i | input | 6 | Dead time in clock cycles |
| duty_i | input | 60 | Duty words of the phases, phase k in bits [10k+9:10k] |
| pwm_o | output | 6 | High-side command of each phase |
| lsd_o | output | 6 | Low-side command of each phase |

## Verification
The assertions assume that the configuration words and the flags are synchronous to the clock. They also assume that the dead-time word is narrower than the period word, so the clamp arithmetic never wraps. The bench changes every input on the falling edge and keeps all words within their port widths. It uses the all-zero and above-range phase-count values to reach the count correction.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  // smallest period the scheduler will run, in clock cycles
  localparam int unsigned PER_FLOOR = 4;
endpackage

// File: rtl/mpwm_sched.sv
module mpwm_sched
  import mpwm_pkg::*;
#(
  parameter int unsigned NUM_PH = 6,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned NPH_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [NPH_W-1:0]  nph_i,
  output logic [NUM_PH-1:0] start_o,
  output logic [NUM_PH-1:0] act_o,
  output logic [CNT_W-1:0]  per_o
);
  localparam int unsigned OFF_W = CNT_W + NPH_W;
  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(PER_FLOOR);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, per_q;
  logic [NPH_W-1:0] nph_q;
  logic [CNT_W-1:0] per_fix;
  logic [NPH_W-1:0] nph_fix;
  logic             wrap;

  always_comb begin
    per_fix = (period_i < PER_MIN) ? PER_MIN : period_i;
    if (nph_i == '0)                      nph_fix = NPH_W'(1);
    else if (nph_i > NPH_W'(NUM_PH))      nph_fix = NPH_W'(NUM_PH);
    else                                  nph_fix = nph_i;
    wrap = run_q && (cnt_q == per_q - 1'b1);
  end

  // master period counter; period and count reload only at its wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      per_q <= PER_MIN;
      nph_q <= NPH_W'(1);
    end else if (!run_q || wrap) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      per_q <= per_fix;
      nph_q <= nph_fix;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign per_o = per_q;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_off
    logic [OFF_W-1:0] prod, off;
    assign prod       = OFF_W'(k) * OFF_W'(per_q);
    assign off        = prod / OFF_W'(nph_q);
    assign start_o[k] = run_q && ({{NPH_W{1'b0}}, cnt_q} == off);
    assign act_o[k]   = (NPH_W'(k) < nph_q);
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < per_q));
  p_per_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q >= PER_MIN);
  p_count_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nph_q != '0) && (nph_q <= NPH_W'(NUM_PH)));
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned DT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             act_i,
  input  logic             en_i,
  input  logic             droop_i,
  input  logic             over_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             pwm_o,
  output logic             lsd_o
);
  localparam int unsigned SW = CNT_W + 2;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, duty_q, per_q;
  logic [DT_W-1:0]  dead_q, g_lo_q, g_hi_q;
  logic [SW-1:0]    two_dead, lim;
  logic [CNT_W-1:0] duty_fix;
  logic             base_hi, base_lo, live;

  always_comb begin
    two_dead = SW'(dead_i) << 1;
    lim      = (SW'(per_i) > two_dead) ? SW'(per_i) - two_dead : '0;
    duty_fix = (SW'(duty_i) > lim) ? lim[CNT_W-1:0] : duty_i;
  end

  // words are latched only at this phase's own period start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      duty_q <= '0;
      per_q  <= '0;
      dead_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      duty_q <= duty_fix;
      per_q  <= per_i;
      dead_q <= dead_i;
    end else if (run_q && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    base_hi = run_q && (cnt_q < duty_q);
    base_lo = run_q
           && (SW'(cnt_q) >= SW'(duty_q) + SW'(dead_q))
           && (SW'(cnt_q) + SW'(dead_q) < SW'(per_q));
    live    = en_i && act_i && run_q;
    pwm_o   = live && (g_lo_q == '0) && (droop_i || (!over_i && base_hi));
    lsd_o   = live && (g_hi_q == '0) && !droop_i && !over_i && base_lo;
  end

  // guards enforce the gap on every transition, overrides included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_lo_q <= '0;
      g_hi_q <= '0;
    end else begin
      if (lsd_o)               g_lo_q <= dead_q;
      else if (g_lo_q != '0)   g_lo_q <= g_lo_q - 1'b1;
      if (pwm_o)               g_hi_q <= dead_q;
      else if (g_hi_q != '0)   g_hi_q <= g_hi_q - 1'b1;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_o && lsd_o));
  p_lo_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_o) && ($past(dead_q) != '0)) |-> !$past(lsd_o));
  p_hi_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lsd_o) && ($past(dead_q) != '0)) |-> !$past(pwm_o));
  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((duty_q == '0) || (SW'(duty_q) + (SW'(dead_q) << 1) <= SW'(per_q))));
  p_droop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    droop_i |-> !lsd_o);
  p_over_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_i && !droop_i) |-> (!pwm_o && !lsd_o));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i) |=> ($stable(duty_q) && $stable(dead_q)));
endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
  import mpwm_pkg::*;
#(
  parameter  int unsigned NUM_PH = 6,
  parameter  int unsigned CNT_W  = 10,
  parameter  int unsigned DT_W   = 6,
  localparam int unsigned NPH_W  = $clog2(NUM_PH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     droop_i,
  input  logic                     over_i,
  input  logic [NPH_W-1:0]         nph_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [DT_W-1:0]          dead_i,
  input  logic [NUM_PH*CNT_W-1:0]  duty_i,
  output logic [NUM_PH-1:0]        pwm_o,
  output logic [NUM_PH-1:0]        lsd_o
);
  logic [NUM_PH-1:0] start, act;
  logic [CNT_W-1:0]  per;

  mpwm_sched #(
    .NUM_PH (NUM_PH),
    .CNT_W  (CNT_W),
    .NPH_W  (NPH_W)
  ) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .nph_i    (nph_i),
    .start_o  (start),
    .act_o    (act),
    .per_o    (per)
  );

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    mpwm_chan #(
      .CNT_W (CNT_W),
      .DT_W  (DT_W)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start[k]),
      .act_i   (act[k]),
      .en_i    (en_i),
      .droop_i (droop_i),
      .over_i  (over_i),
      .per_i   (per),
      .duty_i  (duty_i[k*CNT_W +: CNT_W]),
      .dead_i  (dead_i),
      .pwm_o   (pwm_o[k]),
      .lsd_o   (lsd_o[k])
    );
  end

  p_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ((pwm_o == '0) && (lsd_o == '0)));
endmodule

// File: tb/mphase_pwm_bench.sv
module mphase_pwm_bench;
  localparam int NUM_PH = 6;
  localparam int CNT_W  = 10;
  localparam int DT_W   = 6;
  localparam int NV     = 7;
  localparam int SETTLE = 400;

  // nph, period, dead, duty, window, exp high, exp low, exp phase-1 offset (0 = skip), last phase active
  localparam int V_NPH [NV] = '{1, 2, 3, 6, 4, 7, 1};
  localparam int V_PER [NV] = '{20, 30, 40, 60, 24, 36, 2};
  localparam int V_DT  [NV] = '{2, 3, 1, 4, 0, 2, 0};
  localparam int V_DUT [NV] = '{6, 10, 5, 58, 0, 9, 1};
  localparam int V_WIN [NV] = '{20, 30, 40, 60, 24, 36, 4};
  localparam int V_HI  [NV] = '{6, 10, 5, 52, 0, 9, 1};
  localparam int V_LO  [NV] = '{10, 14, 33, 0, 24, 23, 3};
  localparam int V_OFF [NV] = '{0, 15, 13, 10, 0, 6, 0};
  localparam int V_LAST[NV] = '{0, 0, 0, 1, 0, 1, 0};

  logic                    clk = 1'b0;
  logic                    rst_ni;
  logic                    en_i, droop_i, over_i;
  logic [2:0]              nph_i;
  logic [CNT_W-1:0]        period_i;
  logic [DT_W-1:0]         dead_i;
  logic [NUM_PH*CNT_W-1:0] duty_i;
  logic [NUM_PH-1:0]       pwm_o, lsd_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mphase_pwm u_mphase_pwm (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .droop_i  (droop_i),
    .over_i   (over_i),
    .nph_i    (nph_i),
    .period_i (period_i),
    .dead_i   (dead_i),
    .duty_i   (duty_i),
    .pwm_o    (pwm_o),
    .lsd_o    (lsd_o)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int n, input int p, input int t, input int d);
    nph_i    = 3'(n);
    period_i = CNT_W'(p);
    dead_i   = DT_W'(t);
    duty_i   = {NUM_PH{CNT_W'(d)}};
  endtask

  task automatic count_win(input int ph, input int win, output int hi, output int lo);
    hi = 0;
    lo = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      hi += int'(pwm_o[ph]);
      lo += int'(lsd_o[ph]);
    end
  endtask

  task automatic wait_rise(input int ph);
    logic prev;
    prev = pwm_o[ph];
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pwm_o[ph] && !prev) return;
      prev = pwm_o[ph];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, hi2, lo2, n;
    logic prev;
    rst_ni  = 1'b0;
    en_i    = 1'b1;
    droop_i = 1'b1;
    over_i  = 1'b0;
    set_cfg(1, 20, 2, 6);
    repeat (3) @(negedge clk);
    check_eq("R11 pwm low in reset under droop", int'(pwm_o), 0);
    check_eq("R11 lsd low in reset", int'(lsd_o), 0);
    droop_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      set_cfg(V_NPH[v], V_PER[v], V_DT[v], V_DUT[v]);
      repeat (SETTLE) @(negedge clk);
      count_win(0, V_WIN[v], hi, lo);
      check_eq($sformatf("R4 R5 high time vec %0d", v), hi, V_HI[v]);
      check_eq($sformatf("R4 low time vec %0d", v), lo, V_LO[v]);
      count_win(NUM_PH - 1, V_WIN[v], hi2, lo2);
      check_eq($sformatf("R10 last phase activity vec %0d", v), int'((hi2 + lo2) > 0), V_LAST[v]);
      if (V_OFF[v] != 0) begin
        wait_rise(0);
        n = 0;
        prev = pwm_o[1];
        for (int i = 0; i < 2000; i++) begin
          @(negedge clk);
          n++;
          if (pwm_o[1] && !prev) break;
          prev = pwm_o[1];
        end
        check_eq($sformatf("R3 phase 1 offset vec %0d", v), n, V_OFF[v]);
      end
    end

    // R10: count of zero behaves as one
    set_cfg(0, 20, 1, 5);
    repeat (SETTLE) @(negedge clk);
    count_win(0, 20, hi, lo);
    check_eq("R10 zero count phase 0 high", hi, 5);
    count_win(1, 20, hi, lo);
    check_eq("R10 zero count phase 1 idle", hi + lo, 0);

    // R2 and R1: dead-time gaps and non-overlap
    set_cfg(1, 20, 2, 6);
    repeat (SETTLE) @(negedge clk);
    wait_rise(0);
    for (int i = 0; i < 100 && pwm_o[0]; i++) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100 && !lsd_o[0]; i++) begin
      n++;
      @(negedge clk);
    end
    check_eq("R2 gap high to low side", n, 2);
    for (int i = 0; i < 100 && lsd_o[0]; i++) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100 && !pwm_o[0]; i++) begin
      n++;
      @(negedge clk);
    end
    check_eq("R2 gap low to high side", n, 2);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n += $countones(pwm_o & lsd_o);
    end
    check_eq("R1 overlap cycles", n, 0);

    // R6: enable
    set_cfg(2, 40, 3, 8);
    repeat (SETTLE) @(negedge clk);
    en_i = 1'b0;
    count_win(0, 40, hi, lo);
    count_win(1, 40, hi2, lo2);
    check_eq("R6 disabled outputs", hi + lo + hi2 + lo2, 0);
    en_i = 1'b1;
    repeat (200) @(negedge clk);
    count_win(0, 40, hi, lo);
    check_eq("R6 resumed high time", hi, 8);

    // R7: droop, then precedence over overshoot
    droop_i = 1'b1;
    repeat (4) @(negedge clk);
    count_win(0, 40, hi, lo);
    check_eq("R7 droop phase 0 high", hi, 40);
    check_eq("R7 droop phase 0 low side", lo, 0);
    count_win(1, 40, hi, lo);
    check_eq("R7 droop phase 1 high", hi, 40);
    count_win(2, 20, hi, lo);
    check_eq("R7 droop inactive phase idle", hi + lo, 0);
    over_i = 1'b1;
    count_win(0, 20, hi, lo);
    check_eq("R7 droop beats overshoot", hi, 20);

    // R8: overshoot alone
    droop_i = 1'b0;
    count_win(0, 20, hi, lo);
    count_win(1, 20, hi2, lo2);
    check_eq("R8 overshoot outputs off", hi + lo + hi2 + lo2, 0);
    over_i = 1'b0;
    repeat (200) @(negedge clk);
    count_win(0, 40, hi, lo);
    check_eq("R8 recovered high time", hi, 8);

    // R9: duty change mid-pulse waits for next period
    set_cfg(1, 40, 2, 10);
    repeat (SETTLE) @(negedge clk);
    wait_rise(0);
    n = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!pwm_o[0]) break;
      n++;
      if (n == 3) duty_i = {NUM_PH{CNT_W'(30)}};
    end
    check_eq("R9 pulse in progress unchanged", n, 10);
    wait_rise(0);
    n = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!pwm_o[0]) break;
      n++;
    end
    check_eq("R9 next pulse uses new duty", n, 30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule